// File: doc/BRIEF.md
# Thread-Block Group Coalescer

This block sits beside the kernel scheduler of a many-core compute engine. Compute units ask it, at run time, to launch small groups of thread blocks. Each request carries a kernel function identifier, the block dimensions, a three-dimensional group size and the address of the group's parameters. The block compares the request against every live kernel slot in a single cycle. When a live kernel has the same function and block dimensions, the group is attached to that kernel. It gets a slot in a group table, and that slot is linked onto the tail of the kernel's list of pending groups. When no live kernel fits, the request takes a fresh kernel slot of its own.

Each kernel slot keeps a head pointer and a tail pointer into its list, together with a single ready flag. The scheduler drains the lists with a pop command. It reports through a separate input that all of a kernel's blocks have been issued, which clears the flag. Attaching a new group sets the flag again. The scheduler retires finished kernels, and it returns group slots once their blocks have completed. Allocating parameter memory and dispatching blocks are left to neighbouring logic.

Top module: `tbg_coalescer`

## Requirements
- R1: After reset no kernel slot is live, every ready flag is 0, `rsp_valid` is 0 and `req_ready` is 1.
- R2: A request whose function id and block dimensions equal those of a live kernel slot is attached to that slot, provided a group slot is free. The response in the cycle after acceptance shows `rsp_coalesced`=1 and the kernel index. When several slots match, the lowest index wins.
- R3: A request that matches no live slot is installed in the lowest-numbered free kernel slot. The response in the next cycle shows `rsp_coalesced`=0 and that index, and the slot becomes live with its ready flag set.
- R4: Group slots that were never used are handed out in ascending order from 0. Returned slots are handed out before unused ones, the most recently returned first.
- R5: A pop on a kernel returns, one cycle later, its attached groups in the order they were attached, each with its slot index, group size and parameter address (`pop_rsp_hit`=1). A pop on an empty list returns `pop_rsp_hit`=0.
- R6: An issue-done input clears the kernel's ready flag. Attaching a group to that kernel sets the flag again.
- R7: When the group table is full, a matching request is installed as a new kernel slot instead of being attached.
- R8: When the request can neither be attached nor installed, `req_ready` stays 0 and the request waits. It is accepted once a kernel slot is retired.
- R9: In any cycle where a pop or a retire is presented, `req_ready` is 0.
- R10: Retiring a kernel clears its live bit and its ready flag, and its configuration no longer matches later requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Launch request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_func | input | FUNC_W | Kernel function identifier |
| req_bdim | input | 3*BDIM_W | Block dimensions, z:y:x |
| req_gx | input | GDIM_W | Group size, x |
| req_gy | input | GDIM_W | Group size, y |
| req_gz | input | GDIM_W | Group size, z |
| req_param | input | ADDR_W | Parameter address |
| rsp_valid | output | 1 | Placement result present |
| rsp_coalesced | output | 1 | 1 = attached, 0 = new kernel |
| rsp_kde | output | log2(NUM_KDE) | Kernel slot used |
| rsp_age | output | log2(AGT_DEPTH) | Group slot used (0 for a new kernel) |
| pop_valid | input | 1 | Take the head group of a kernel |
| pop_kde | input | log2(NUM_KDE) | Kernel to pop |
| pop_rsp_valid | output | 1 | Pop result present |
| pop_rsp_hit | output | 1 | A group was returned |
| pop_rsp_age | output | log2(AGT_DEPTH) | Group slot returned |
| pop_rsp_gx | output | GDIM_W | Group size x |
| pop_rsp_gy | output | GDIM_W | Group size y |
| pop_rsp_gz | output | GDIM_W | Group size z |
| pop_rsp_param | output | ADDR_W | Parameter address |
| issue_done_valid | input | 1 | All blocks of a kernel issued |
| issue_done_kde | input | log2(NUM_KDE) | Kernel concerned |
| retire_valid | input | 1 | Free a kernel slot |
| retire_kde | input | log2(NUM_KDE) | Kernel to free |
| grp_free_valid | input | 1 | Return a group slot |
| grp_free_age | input | log2(AGT_DEPTH) | Group slot returned |
| kde_valid_o | output | NUM_KDE | Live bit per kernel slot |
| kde_ready_o | output | NUM_KDE | Ready flag per kernel slot |

## Verification
The bench checks that a function match with different block dimensions does not coalesce. A design that compared only the function id would attach such a group to the wrong kernel. It pops lists down to empty and then appends again, which catches a head pointer that fails to restart and hands back a stale group. The bench returns group slots out of order and fills the group table, and the expected slot numbers then expose a free list that is FIFO instead of LIFO, or a full table that stalls when it should install. It retires kernels while a request waits and then reuses their configuration. A design that left a stale live bit set would coalesce into the dead slot or keep stalling.

// File: rtl/tbg_pkg.sv
// Shared types for the thread-block group coalescer.
package tbg_pkg;
    // Placement outcome of an accepted launch request.
    typedef enum logic {
        PLACE_NEW_KERNEL = 1'b0,
        PLACE_COALESCED  = 1'b1
    } place_e;
endpackage

// File: rtl/tbg_free_list.sv
// Group-slot allocator. Unused slots are handed out in ascending order.
// Returned slots go on a stack and are reused before unused ones.
// Assumes: alloc_en only when avail, and free_idx is a slot currently held.
module tbg_free_list #(
    parameter int DEPTH = 1024,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_en,
    output logic             avail,
    output logic [IDX_W-1:0] alloc_idx,
    input  logic             free_en,
    input  logic [IDX_W-1:0] free_idx
);
    localparam int CNT_W = IDX_W + 1;
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

    logic [IDX_W-1:0] stack_q [DEPTH];
    logic [CNT_W-1:0] sp_q;
    logic [CNT_W-1:0] fresh_q;
    logic             stack_nz;
    logic [IDX_W-1:0] top_slot;
    logic [IDX_W-1:0] wr_slot;

    // Decide where the next slot comes from and where a returned one goes.
    always_comb begin
        stack_nz  = (sp_q != '0);
        top_slot  = IDX_W'(sp_q - 1'b1);
        avail     = stack_nz || (fresh_q != DEPTH_C);
        alloc_idx = stack_nz ? stack_q[top_slot] : fresh_q[IDX_W-1:0];
        wr_slot   = (alloc_en && stack_nz) ? top_slot : sp_q[IDX_W-1:0];
    end

    // Stack pointer and unused-slot counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_q    <= '0;
            fresh_q <= '0;
        end else begin
            case ({alloc_en, free_en})
                2'b10: begin
                    if (stack_nz) sp_q <= sp_q - 1'b1;
                    else          fresh_q <= fresh_q + 1'b1;
                end
                2'b01: sp_q <= sp_q + 1'b1;
                2'b11: begin
                    if (!stack_nz) begin
                        fresh_q <= fresh_q + 1'b1;
                        sp_q    <= CNT_W'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    // Store a returned slot on the stack.
    always_ff @(posedge clk) begin
        if (free_en) stack_q[wr_slot] <= free_idx;
    end

    // R4: never hand out a slot when none is available.
    p_alloc_has_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en |-> avail);
    // R4: a slot can only come back while at least one is held.
    p_free_outstanding_r4: assert property (@(posedge clk) disable iff (!rst_n)
        free_en |-> (fresh_q > sp_q));
endmodule

// File: rtl/tbg_group_table.sv
// Storage for attached groups: the group size, the parameter address and
// a next link per slot. Writing a slot clears its link. Linking sets the
// link of an older slot. The read port is combinational.
// Assumes: a slot is never linked to itself in the cycle it is written.
module tbg_group_table #(
    parameter int DEPTH  = 1024,
    parameter int IDX_W  = $clog2(DEPTH),
    parameter int GDIM_W = 16,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [GDIM_W-1:0] wr_gx,
    input  logic [GDIM_W-1:0] wr_gy,
    input  logic [GDIM_W-1:0] wr_gz,
    input  logic [ADDR_W-1:0] wr_param,
    input  logic              link_en,
    input  logic [IDX_W-1:0]  link_from,
    input  logic [IDX_W-1:0]  link_to,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [GDIM_W-1:0] rd_gx,
    output logic [GDIM_W-1:0] rd_gy,
    output logic [GDIM_W-1:0] rd_gz,
    output logic [ADDR_W-1:0] rd_param,
    output logic              rd_next_vld,
    output logic [IDX_W-1:0]  rd_next
);
    logic [GDIM_W-1:0] gx_q    [DEPTH];
    logic [GDIM_W-1:0] gy_q    [DEPTH];
    logic [GDIM_W-1:0] gz_q    [DEPTH];
    logic [ADDR_W-1:0] param_q [DEPTH];
    logic [IDX_W-1:0]  next_q  [DEPTH];
    logic [DEPTH-1:0]  next_vld_q;

    // Payload storage for a slot when a group is attached.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            gx_q[wr_idx]    <= wr_gx;
            gy_q[wr_idx]    <= wr_gy;
            gz_q[wr_idx]    <= wr_gz;
            param_q[wr_idx] <= wr_param;
        end
        if (link_en) next_q[link_from] <= link_to;
    end

    // Link valid bits: cleared when a slot is written, set when linked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            next_vld_q <= '0;
        end else begin
            if (wr_en)   next_vld_q[wr_idx]    <= 1'b0;
            if (link_en) next_vld_q[link_from] <= 1'b1;
        end
    end

    // Combinational read of one slot.
    always_comb begin
        rd_gx       = gx_q[rd_idx];
        rd_gy       = gy_q[rd_idx];
        rd_gz       = gz_q[rd_idx];
        rd_param    = param_q[rd_idx];
        rd_next     = next_q[rd_idx];
        rd_next_vld = next_vld_q[rd_idx];
    end

    // R5: the tail being linked is never the slot being written.
    p_link_not_new_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (link_en && wr_en) |-> (link_from != wr_idx));
    // R5: a linked slot shows a valid link in the following cycle.
    p_link_sticks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (link_en && !(wr_en && wr_idx == link_from)) |=> next_vld_q[$past(link_from)]);
endmodule

// File: rtl/tbg_kernel_table.sv
// Kernel distributor slots. Each slot holds a live bit, a ready flag, the
// function id and the block dimensions, plus head and tail pointers into
// the group list. All slots are compared in parallel, and the lowest
// matching slot and the lowest free slot are selected.
// Assumes: pop and retire never come in the same cycle as install or append.
module tbg_kernel_table #(
    parameter int NUM_KDE = 8,
    parameter int KDE_W   = $clog2(NUM_KDE),
    parameter int FUNC_W  = 8,
    parameter int CFG_W   = 30,
    parameter int IDX_W   = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FUNC_W-1:0]  cmp_func,
    input  logic [CFG_W-1:0]   cmp_bdim,
    output logic               match_any,
    output logic [KDE_W-1:0]   match_idx,
    output logic               free_any,
    output logic [KDE_W-1:0]   free_idx,
    input  logic               inst_en,
    input  logic [KDE_W-1:0]   inst_idx,
    input  logic               app_en,
    input  logic [KDE_W-1:0]   app_kde,
    input  logic [IDX_W-1:0]   app_age,
    output logic               app_list_vld,
    output logic [IDX_W-1:0]   app_tail,
    input  logic               pop_en,
    input  logic [KDE_W-1:0]   pop_kde,
    output logic               pop_head_vld,
    output logic [IDX_W-1:0]   pop_head,
    input  logic               pop_next_vld,
    input  logic [IDX_W-1:0]   pop_next,
    input  logic               done_en,
    input  logic [KDE_W-1:0]   done_kde,
    input  logic               ret_en,
    input  logic [KDE_W-1:0]   ret_kde,
    output logic [NUM_KDE-1:0] valid_vec,
    output logic [NUM_KDE-1:0] ready_vec
);
    logic [NUM_KDE-1:0]            match_vec;
    logic [NUM_KDE-1:0]            hv_vec;
    logic [NUM_KDE-1:0][IDX_W-1:0] head_p;
    logic [NUM_KDE-1:0][IDX_W-1:0] tail_p;

    for (genvar g = 0; g < NUM_KDE; g++) begin : g_slot
        logic              e_valid;
        logic              e_ready;
        logic              e_hv;
        logic [FUNC_W-1:0] e_func;
        logic [CFG_W-1:0]  e_bdim;
        logic [IDX_W-1:0]  e_head;
        logic [IDX_W-1:0]  e_tail;

        // Per-slot state update; a later statement overrides an earlier one.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                e_valid <= 1'b0;
                e_ready <= 1'b0;
                e_hv    <= 1'b0;
                e_func  <= '0;
                e_bdim  <= '0;
                e_head  <= '0;
                e_tail  <= '0;
            end else begin
                if (ret_en && ret_kde == KDE_W'(g)) begin
                    e_valid <= 1'b0;
                    e_ready <= 1'b0;
                    e_hv    <= 1'b0;
                end
                if (inst_en && inst_idx == KDE_W'(g)) begin
                    e_valid <= 1'b1;
                    e_ready <= 1'b1;
                    e_hv    <= 1'b0;
                    e_func  <= cmp_func;
                    e_bdim  <= cmp_bdim;
                end
                if (done_en && done_kde == KDE_W'(g)) e_ready <= 1'b0;
                if (app_en && app_kde == KDE_W'(g)) begin
                    e_ready <= 1'b1;
                    e_tail  <= app_age;
                    if (!e_hv) begin
                        e_hv   <= 1'b1;
                        e_head <= app_age;
                    end
                end
                if (pop_en && pop_kde == KDE_W'(g) && e_hv) begin
                    if (pop_next_vld) e_head <= pop_next;
                    else              e_hv   <= 1'b0;
                end
            end
        end

        assign match_vec[g] = e_valid && (e_func == cmp_func) && (e_bdim == cmp_bdim);
        assign valid_vec[g] = e_valid;
        assign ready_vec[g] = e_ready;
        assign hv_vec[g]    = e_hv;
        assign head_p[g]    = e_head;
        assign tail_p[g]    = e_tail;
    end

    // Lowest-index priority select of matching and free slots.
    always_comb begin
        match_any = |match_vec;
        free_any  = ~&valid_vec;
        match_idx = '0;
        free_idx  = '0;
        for (int i = NUM_KDE - 1; i >= 0; i--) begin
            if (match_vec[i]) match_idx = KDE_W'(i);
            if (!valid_vec[i]) free_idx = KDE_W'(i);
        end
    end

    // List pointers of the slots addressed by append and pop.
    always_comb begin
        app_list_vld = hv_vec[app_kde];
        app_tail     = tail_p[app_kde];
        pop_head_vld = hv_vec[pop_kde];
        pop_head     = head_p[pop_kde];
    end

    // R3: install only into a slot that is not live.
    p_install_into_free_r3: assert property (@(posedge clk) disable iff (!rst_n)
        inst_en |-> !valid_vec[inst_idx]);
    // R3: an installed slot is live and ready one cycle later.
    p_install_live_r3: assert property (@(posedge clk) disable iff (!rst_n)
        inst_en |=> (valid_vec[$past(inst_idx)] && ready_vec[$past(inst_idx)]));
    // R2: appends only go to live kernels.
    p_append_to_live_r2: assert property (@(posedge clk) disable iff (!rst_n)
        app_en |-> valid_vec[app_kde]);
    // R6: an append re-arms the ready flag and leaves a non-empty list.
    p_append_rearms_r6: assert property (@(posedge clk) disable iff (!rst_n)
        app_en |=> (ready_vec[$past(app_kde)] && hv_vec[$past(app_kde)]));
    // R10: a retired slot is neither live nor ready afterwards.
    p_retire_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_en && !inst_en) |=> (!valid_vec[$past(ret_kde)] && !ready_vec[$past(ret_kde)]));
endmodule

// File: rtl/tbg_coalescer.sv
// Thread-block group coalescer top. Takes one launch request per cycle.
// A request is attached to a live kernel with an identical configuration
// when a group slot is free. Otherwise it is installed as a new kernel, and
// it stalls when no kernel slot is free. Pop and retire commands take
// priority over requests. All results are registered, one cycle later.
module tbg_coalescer
    import tbg_pkg::*;
#(
    parameter int NUM_KDE   = 8,
    parameter int AGT_DEPTH = 1024,
    parameter int FUNC_W    = 8,
    parameter int BDIM_W    = 10,
    parameter int GDIM_W    = 16,
    parameter int ADDR_W    = 32,
    localparam int KDE_W    = $clog2(NUM_KDE),
    localparam int AGE_W    = $clog2(AGT_DEPTH),
    localparam int CFG_W    = 3 * BDIM_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [FUNC_W-1:0]  req_func,
    input  logic [CFG_W-1:0]   req_bdim,
    input  logic [GDIM_W-1:0]  req_gx,
    input  logic [GDIM_W-1:0]  req_gy,
    input  logic [GDIM_W-1:0]  req_gz,
    input  logic [ADDR_W-1:0]  req_param,
    output logic               rsp_valid,
    output logic               rsp_coalesced,
    output logic [KDE_W-1:0]   rsp_kde,
    output logic [AGE_W-1:0]   rsp_age,
    input  logic               pop_valid,
    input  logic [KDE_W-1:0]   pop_kde,
    output logic               pop_rsp_valid,
    output logic               pop_rsp_hit,
    output logic [AGE_W-1:0]   pop_rsp_age,
    output logic [GDIM_W-1:0]  pop_rsp_gx,
    output logic [GDIM_W-1:0]  pop_rsp_gy,
    output logic [GDIM_W-1:0]  pop_rsp_gz,
    output logic [ADDR_W-1:0]  pop_rsp_param,
    input  logic               issue_done_valid,
    input  logic [KDE_W-1:0]   issue_done_kde,
    input  logic               retire_valid,
    input  logic [KDE_W-1:0]   retire_kde,
    input  logic               grp_free_valid,
    input  logic [AGE_W-1:0]   grp_free_age,
    output logic [NUM_KDE-1:0] kde_valid_o,
    output logic [NUM_KDE-1:0] kde_ready_o
);
    logic              match_any, free_any, age_avail;
    logic [KDE_W-1:0]  match_idx, free_idx;
    logic [AGE_W-1:0]  alloc_idx;
    logic              app_list_vld, pop_head_vld;
    logic [AGE_W-1:0]  app_tail, pop_head;
    logic [GDIM_W-1:0] rd_gx, rd_gy, rd_gz;
    logic [ADDR_W-1:0] rd_param;
    logic              rd_next_vld;
    logic [AGE_W-1:0]  rd_next;
    logic              ctl_busy, coal_ok, accept, do_app, do_inst;
    place_e            place_q;

    // Arbitration and placement decision for the current request.
    always_comb begin
        ctl_busy  = pop_valid || retire_valid;
        coal_ok   = match_any && age_avail;
        req_ready = !ctl_busy && (coal_ok || free_any);
        accept    = req_valid && req_ready;
        do_app    = accept && coal_ok;
        do_inst   = accept && !coal_ok;
    end

    tbg_kernel_table #(
        .NUM_KDE (NUM_KDE), .KDE_W (KDE_W), .FUNC_W (FUNC_W),
        .CFG_W   (CFG_W),   .IDX_W (AGE_W)
    ) kt_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmp_func     (req_func),
        .cmp_bdim     (req_bdim),
        .match_any    (match_any),
        .match_idx    (match_idx),
        .free_any     (free_any),
        .free_idx     (free_idx),
        .inst_en      (do_inst),
        .inst_idx     (free_idx),
        .app_en       (do_app),
        .app_kde      (match_idx),
        .app_age      (alloc_idx),
        .app_list_vld (app_list_vld),
        .app_tail     (app_tail),
        .pop_en       (pop_valid),
        .pop_kde      (pop_kde),
        .pop_head_vld (pop_head_vld),
        .pop_head     (pop_head),
        .pop_next_vld (rd_next_vld),
        .pop_next     (rd_next),
        .done_en      (issue_done_valid),
        .done_kde     (issue_done_kde),
        .ret_en       (retire_valid),
        .ret_kde      (retire_kde),
        .valid_vec    (kde_valid_o),
        .ready_vec    (kde_ready_o)
    );

    tbg_free_list #(.DEPTH (AGT_DEPTH), .IDX_W (AGE_W)) fl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .alloc_en  (do_app),
        .avail     (age_avail),
        .alloc_idx (alloc_idx),
        .free_en   (grp_free_valid),
        .free_idx  (grp_free_age)
    );

    tbg_group_table #(
        .DEPTH (AGT_DEPTH), .IDX_W (AGE_W), .GDIM_W (GDIM_W), .ADDR_W (ADDR_W)
    ) gt_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (do_app),
        .wr_idx      (alloc_idx),
        .wr_gx       (req_gx),
        .wr_gy       (req_gy),
        .wr_gz       (req_gz),
        .wr_param    (req_param),
        .link_en     (do_app && app_list_vld),
        .link_from   (app_tail),
        .link_to     (alloc_idx),
        .rd_idx      (pop_head),
        .rd_gx       (rd_gx),
        .rd_gy       (rd_gy),
        .rd_gz       (rd_gz),
        .rd_param    (rd_param),
        .rd_next_vld (rd_next_vld),
        .rd_next     (rd_next)
    );

    // Registered placement response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            place_q   <= PLACE_NEW_KERNEL;
            rsp_kde   <= '0;
            rsp_age   <= '0;
        end else begin
            rsp_valid <= accept;
            if (accept) begin
                place_q <= coal_ok ? PLACE_COALESCED : PLACE_NEW_KERNEL;
                rsp_kde <= coal_ok ? match_idx : free_idx;
                rsp_age <= coal_ok ? alloc_idx : '0;
            end
        end
    end

    assign rsp_coalesced = (place_q == PLACE_COALESCED);

    // Registered pop response carrying the head group of the list.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pop_rsp_valid <= 1'b0;
            pop_rsp_hit   <= 1'b0;
            pop_rsp_age   <= '0;
            pop_rsp_gx    <= '0;
            pop_rsp_gy    <= '0;
            pop_rsp_gz    <= '0;
            pop_rsp_param <= '0;
        end else begin
            pop_rsp_valid <= pop_valid;
            if (pop_valid) begin
                pop_rsp_hit   <= pop_head_vld;
                pop_rsp_age   <= pop_head;
                pop_rsp_gx    <= rd_gx;
                pop_rsp_gy    <= rd_gy;
                pop_rsp_gz    <= rd_gz;
                pop_rsp_param <= rd_param;
            end
        end
    end

    // R2: every accepted request produces a response next cycle.
    p_rsp_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> rsp_valid);
    // R5: a pop on a non-empty list reports a hit.
    p_pop_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_valid && pop_head_vld) |=> (pop_rsp_valid && pop_rsp_hit));
    // R8: a waiting request with no free kernel slot leaves all slots live.
    p_stall_only_when_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready && !pop_valid && !retire_valid) |-> (&kde_valid_o));
    // R1: no response without a prior acceptance.
    p_no_spurious_rsp_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid && req_ready));
endmodule

// File: tb/tbg_coalescer_tb_top.sv
`timescale 1ns/1ps
module tbg_coalescer_tb_top;
    localparam int NK = 4;
    localparam int ND = 4;
    localparam logic [29:0] D1 = {10'd1, 10'd4, 10'd8};
    localparam logic [29:0] D2 = {10'd1, 10'd4, 10'd16};

    typedef struct packed {
        logic [7:0]  func;
        logic [29:0] bdim;
        logic        coal;
        logic [1:0]  kde;
        logic [1:0]  age;
    } vec_t;

    // Launch sequence, with the expected placement of each request.
    localparam vec_t VECS [6] = '{
        '{8'd1, D1, 1'b0, 2'd0, 2'd0},   // R3 new kernel 0
        '{8'd1, D1, 1'b1, 2'd0, 2'd0},   // R2 attach, group slot 0 (R4)
        '{8'd2, D1, 1'b0, 2'd1, 2'd0},   // R3 new kernel 1
        '{8'd1, D1, 1'b1, 2'd0, 2'd1},   // R2 attach, group slot 1
        '{8'd2, D1, 1'b1, 2'd1, 2'd2},   // R2 attach to kernel 1, slot 2
        '{8'd1, D2, 1'b0, 2'd2, 2'd0}    // R2 dims differ: new kernel 2
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [7:0]  req_func = '0;
    logic [29:0] req_bdim = '0;
    logic [15:0] req_gx = '0, req_gy = '0, req_gz = '0;
    logic [31:0] req_param = '0;
    logic        rsp_valid, rsp_coalesced;
    logic [1:0]  rsp_kde, rsp_age;
    logic        pop_valid = 1'b0;
    logic [1:0]  pop_kde = '0;
    logic        pop_rsp_valid, pop_rsp_hit;
    logic [1:0]  pop_rsp_age;
    logic [15:0] pop_rsp_gx, pop_rsp_gy, pop_rsp_gz;
    logic [31:0] pop_rsp_param;
    logic        issue_done_valid = 1'b0;
    logic [1:0]  issue_done_kde = '0;
    logic        retire_valid = 1'b0;
    logic [1:0]  retire_kde = '0;
    logic        grp_free_valid = 1'b0;
    logic [1:0]  grp_free_age = '0;
    logic [3:0]  kde_valid_o, kde_ready_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done_flag = 1'b0;

    always #2.5 clk = ~clk;

    tbg_coalescer #(
        .NUM_KDE (NK), .AGT_DEPTH (ND), .FUNC_W (8),
        .BDIM_W (10), .GDIM_W (16), .ADDR_W (32)
    ) dut_i (.*);

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input logic [63:0] act, input logic [63:0] exp);
        chk(act == exp, req, act, exp);
    endtask

    // Present one request, wait for acceptance, check the response.
    task automatic send(input logic [7:0] f, input logic [29:0] d, input logic [15:0] gx,
                        input logic [31:0] prm, input logic coal, input logic [1:0] kde,
                        input logic [1:0] age, input string req);
        @(negedge clk);
        req_valid = 1'b1; req_func = f; req_bdim = d;
        req_gx = gx; req_gy = 16'd2; req_gz = 16'd3; req_param = prm;
        #1;
        while (!req_ready) begin @(negedge clk); #1; end
        @(negedge clk);
        req_valid = 1'b0;
        chk_eq({req, " rsp_valid"}, 64'(rsp_valid), 64'd1);
        chk_eq({req, " coalesced"}, 64'(rsp_coalesced), 64'(coal));
        chk_eq({req, " kde"}, 64'(rsp_kde), 64'(kde));
        if (coal) chk_eq({req, " age"}, 64'(rsp_age), 64'(age));
    endtask

    task automatic pop(input logic [1:0] k, input logic hit, input logic [1:0] age,
                       input logic [15:0] gx, input logic [31:0] prm, input string req);
        @(negedge clk);
        pop_valid = 1'b1; pop_kde = k;
        @(negedge clk);
        pop_valid = 1'b0;
        chk_eq({req, " pop hit"}, 64'(pop_rsp_hit), 64'(hit));
        if (hit) begin
            chk_eq({req, " pop age"}, 64'(pop_rsp_age), 64'(age));
            chk_eq({req, " pop gx"}, 64'(pop_rsp_gx), 64'(gx));
            chk_eq({req, " pop gz"}, 64'(pop_rsp_gz), 64'd3);
            chk_eq({req, " pop param"}, 64'(pop_rsp_param), 64'(prm));
        end
    endtask

    task automatic free_grp(input logic [1:0] a);
        @(negedge clk); grp_free_valid = 1'b1; grp_free_age = a;
        @(negedge clk); grp_free_valid = 1'b0;
    endtask

    task automatic retire(input logic [1:0] k);
        @(negedge clk); retire_valid = 1'b1; retire_kde = k;
        @(negedge clk); retire_valid = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done_flag) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk_eq("R1 req_ready", 64'(req_ready), 64'd1);
        chk_eq("R1 kde_valid", 64'(kde_valid_o), 64'd0);
        chk_eq("R1 kde_ready", 64'(kde_ready_o), 64'd0);
        chk_eq("R1 rsp_valid", 64'(rsp_valid), 64'd0);

        // Table walk: R2, R3, R4
        for (int i = 0; i < 6; i++) begin
            send(VECS[i].func, VECS[i].bdim, 16'(i + 1), 32'h1000 + 32'(i),
                 VECS[i].coal, VECS[i].kde, VECS[i].age, "R2/R3/R4 table");
        end
        chk_eq("R3 kde_valid", 64'(kde_valid_o), 64'h7);
        chk_eq("R3 kde_ready", 64'(kde_ready_o), 64'h7);

        // R9: pop and request together; request must be held off
        @(negedge clk);
        pop_valid = 1'b1; pop_kde = 2'd0;
        req_valid = 1'b1; req_func = 8'd1; req_bdim = D1;
        #1;
        chk_eq("R9 req_ready during pop", 64'(req_ready), 64'd0);
        @(negedge clk);
        pop_valid = 1'b0; req_valid = 1'b0;
        chk_eq("R9 no rsp", 64'(rsp_valid), 64'd0);
        chk_eq("R5 pop first hit", 64'(pop_rsp_hit), 64'd1);
        chk_eq("R5 pop first age", 64'(pop_rsp_age), 64'd0);
        chk_eq("R5 pop first param", 64'(pop_rsp_param), 64'h1001);

        // R5 second group then empty
        pop(2'd0, 1'b1, 2'd1, 16'd4, 32'h1003, "R5");
        pop(2'd0, 1'b0, 2'd0, 16'd0, 32'h0, "R5 empty");

        // R4 recycle LIFO: return 1 then 0, expect 0 first
        free_grp(2'd1);
        free_grp(2'd0);
        send(8'd1, D1, 16'd7, 32'h2000, 1'b1, 2'd0, 2'd0, "R4 lifo");
        pop(2'd0, 1'b1, 2'd0, 16'd7, 32'h2000, "R5 restart");

        // R6 ready flag clear and re-arm
        @(negedge clk); issue_done_valid = 1'b1; issue_done_kde = 2'd0;
        @(negedge clk); issue_done_valid = 1'b0;
        chk_eq("R6 cleared", 64'(kde_ready_o), 64'h6);
        send(8'd1, D1, 16'd8, 32'h2001, 1'b1, 2'd0, 2'd1, "R6/R4 rearm");
        chk_eq("R6 rearmed", 64'(kde_ready_o), 64'h7);

        // Fill the group table: slot 3 is the last unused
        send(8'd2, D1, 16'd9, 32'h2002, 1'b1, 2'd1, 2'd3, "R4 last");

        // R7 full group table: match falls back to new kernel 3
        send(8'd2, D1, 16'd9, 32'h2003, 1'b0, 2'd3, 2'd0, "R7");
        chk_eq("R7 kde_valid", 64'(kde_valid_o), 64'hF);

        // R8 stall with all kernel slots live, released by a retire
        @(negedge clk);
        req_valid = 1'b1; req_func = 8'd5; req_bdim = D1;
        for (int c = 0; c < 3; c++) begin
            #1;
            chk_eq("R8 stalled", 64'(req_ready), 64'd0);
            @(negedge clk);
        end
        chk_eq("R8 no rsp while stalled", 64'(rsp_valid), 64'd0);
        retire_valid = 1'b1; retire_kde = 2'd2;
        @(negedge clk);
        retire_valid = 1'b0;
        #1;
        chk_eq("R8 released", 64'(req_ready), 64'd1);
        @(negedge clk);
        req_valid = 1'b0;
        chk_eq("R8 rsp", 64'(rsp_valid), 64'd1);
        chk_eq("R8 coalesced", 64'(rsp_coalesced), 64'd0);
        chk_eq("R8 kde", 64'(rsp_kde), 64'd2);

        // R10 retire both kernels of function 2; a new request must not match them
        retire(2'd1);
        retire(2'd3);
        chk_eq("R10 kde_valid", 64'(kde_valid_o), 64'h5);
        chk_eq("R10 kde_ready", 64'(kde_ready_o), 64'h5);
        free_grp(2'd3);
        send(8'd2, D1, 16'd10, 32'h3000, 1'b0, 2'd1, 2'd0, "R10 no stale match");

        done_flag = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule